// File: doc/BRIEF.md
# LPC Host Cycle Sequencer

This block is the host end of a Low Pin Count bus. A client hands it one transfer at a time over a valid/ready request port. A request carries a kind (I/O, memory or DMA), a direction, a 32-bit address, a DMA channel with its terminal-count flag, a DMA size code and up to four bytes of write data. The sequencer then runs the whole bus cycle, one nibble per clock, on a 4-bit multiplexed address/data bus and a frame strobe.

While the host owns the bus it drives the start, cycle-type, address or channel/size, and write-data nibbles. Bus ownership changes hands through two-clock turnarounds. The sequencer then watches the peripheral's open-ended handshake (SYNC) phase: wait codes hold it there, a ready code lets it continue, and an error code or an expired timeout makes it abort the cycle. Read nibbles are collected into a word that is returned with a one-clock completion pulse and an error flag.

Top module: `lpc_host_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `frame_out`, `nib_oe` and `done_valid` are 0.
- R2: One clock after a valid request is accepted, the host drives nibble 0000 with `frame_out` high for exactly that clock. `frame_out` is high at no other time except during an abort.
- R3: The next clock carries the cycle-type nibble {dma, mem, dir, 0}. `req_kind` is encoded 0 = I/O, 1 = memory, 2 = DMA. For I/O and memory, dir equals `req_write`. For DMA, dir is the inverse of `req_write`.
- R4: An I/O cycle then sends the low 16 address bits as 4 nibbles and a memory cycle sends all 32 bits as 8 nibbles, most significant nibble first.
- R5: A DMA cycle sends no address. It sends one nibble {tc, chan[2:0]}, then the size nibble {00, req_size}, where 0, 1 and 3 mean 1, 2 and 4 bytes. I/O and memory cycles always move one byte.
- R6: Write data goes out two nibbles per byte, byte 0 first and the low nibble of each byte first.
- R7: A host turnaround is 1111 driven for one clock, then one clock with `nib_oe` low. A peripheral turnaround is two clocks with `nib_oe` low.
- R8: During the handshake phase `nib_oe` is low. Codes 0101 and 0110 (and any code other than 0000 or 1010) keep the host waiting. Code 0000 moves it on to read data or to the peripheral turnaround.
- R9: Read nibbles are sampled low nibble first into byte positions 0 upward. `rd_data` holds them at completion, and bytes not transferred are zero.
- R10: In a multi-byte DMA transfer every byte has its own handshake. A write repeats data, host turnaround, handshake and peripheral turnaround for each byte. A read repeats handshake and two data nibbles for each byte and has a single peripheral turnaround at the end.
- R11: A handshake code of 1010 ends the cycle. The host drives 1111 with `frame_out` high for ABORT_CLKS clocks and then completes with `done_err` set.
- R12: If `tmo_limit` handshake clocks pass without a 0000 or 1010 code, the host aborts as in R11 and completes with `done_err` set.
- R13: A DMA request with size code 2 makes no bus activity. It completes one clock after acceptance with `done_err` set.
- R14: `done_valid` is high for exactly one clock, after which `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 I/O, 1 memory, 2 DMA |
| req_write | input | 1 | 1 = host sends data to the peripheral |
| req_addr | input | 32 | Target address (I/O uses bits 15:0) |
| req_chan | input | 3 | DMA channel |
| req_tc | input | 1 | DMA terminal count |
| req_size | input | 2 | DMA size code |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| tmo_limit | input | TMO_W | Handshake clocks allowed before abort |
| req_ready | output | 1 | Idle and able to accept a request |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 1 | Completion ended in error |
| rd_data | output | 32 | Read data at completion |
| frame_out | output | 1 | Frame strobe, active high |
| nib_out | output | 4 | Nibble driven by the host |
| nib_oe | output | 1 | Host drives the nibble bus |
| nib_in | input | 4 | Nibble bus as seen from the peripheral side |

## Verification
The bench builds the sequencer with TMO_W = 4, ABORT_CLKS = 4 and a runtime limit of 3 handshake clocks. The short limit lets a handful of wait codes reach the timeout. The bench sweeps every kind and direction, every valid DMA size and 0 to 2 wait codes per byte. A lockstep peripheral model checks each clock's nibble, output enable and frame against a sequence rebuilt from the request. Further cases cover an error code on a later byte, timeouts on memory and DMA cycles, and the rejected size code.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

    typedef enum logic [1:0] {
        K_IO  = 2'd0,
        K_MEM = 2'd1,
        K_DMA = 2'd2
    } xfer_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_CHAN, ST_SIZE,
        ST_HDATA, ST_HTAR1, ST_HTAR2, ST_SYNC, ST_PDATA,
        ST_PTAR1, ST_PTAR2, ST_ABORT, ST_DONE
    } phase_e;

    localparam logic [3:0] NIB_START  = 4'h0;
    localparam logic [3:0] NIB_IDLE   = 4'hF;
    localparam logic [3:0] SYNC_READY = 4'h0;
    localparam logic [3:0] SYNC_ERR   = 4'hA;

    typedef struct packed {
        xfer_kind_e  kind;
        logic        write;
        logic [31:0] addr;
        logic [2:0]  chan;
        logic        tc;
        logic [1:0]  size;
        logic [31:0] wdata;
    } lpc_req_t;

    function automatic logic [3:0] ctype_nibble(input xfer_kind_e k, input logic wr);
        logic is_dma;
        is_dma = (k == K_DMA);
        return {is_dma, k == K_MEM, is_dma ? ~wr : wr, 1'b0};
    endfunction

    function automatic logic [1:0] last_byte_idx(input lpc_req_t r);
        if (r.kind != K_DMA) return 2'd0;
        case (r.size)
            2'd1:    return 2'd1;
            2'd3:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic size_valid(input xfer_kind_e k, input logic [1:0] sz);
        return !(k == K_DMA && sz == 2'd2);
    endfunction

endpackage

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W:0] ONE = 1;

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + ONE[TMO_W-1:0];
    end

    assign expired = run && (({1'b0, cnt} + ONE) >= {1'b0, limit});

endmodule

// File: rtl/lpc_rd_capture.sv
module lpc_rd_capture (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        load,
    input  logic [1:0]  byte_idx,
    input  logic        nib_idx,
    input  logic [3:0]  nib,
    output logic [31:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            data <= '0;
        else if (load)
            data[{byte_idx, nib_idx, 2'b00} +: 4] <= nib;
    end
endmodule

// File: rtl/lpc_host_seq.sv
module lpc_host_seq
    import lpc_host_pkg::*;
#(
    parameter int TMO_W      = 8,
    parameter int ABORT_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_write,
    input  logic [31:0]      req_addr,
    input  logic [2:0]       req_chan,
    input  logic             req_tc,
    input  logic [1:0]       req_size,
    input  logic [31:0]      req_wdata,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             req_ready,
    output logic             done_valid,
    output logic             done_err,
    output logic [31:0]      rd_data,
    output logic             frame_out,
    output logic [3:0]       nib_out,
    output logic             nib_oe,
    input  logic [3:0]       nib_in
);
    localparam int AB_W = $clog2(ABORT_CLKS + 1);
    localparam logic [AB_W-1:0] AB_LAST = AB_W'(ABORT_CLKS - 1);

    phase_e          state;
    lpc_req_t        req;
    logic [2:0]      acnt;
    logic [1:0]      bcnt;
    logic            ncnt;
    logic            err;
    logic [AB_W-1:0] abcnt;
    logic            tmo_expired;
    logic            accept;
    logic            new_ok;

    assign accept = (state == ST_IDLE) && req_valid;
    assign new_ok = size_valid(xfer_kind_e'(req_kind), req_size);

    lpc_sync_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .run(state == ST_SYNC),
        .limit(tmo_limit), .expired(tmo_expired)
    );

    lpc_rd_capture u_cap (
        .clk(clk), .rst(rst), .clear(accept), .load(state == ST_PDATA),
        .byte_idx(bcnt), .nib_idx(ncnt), .nib(nib_in), .data(rd_data)
    );

    always_comb begin
        frame_out = 1'b0;
        nib_oe    = 1'b1;
        nib_out   = NIB_IDLE;
        case (state)
            ST_START: begin frame_out = 1'b1; nib_out = NIB_START; end
            ST_CTYPE: nib_out = ctype_nibble(req.kind, req.write);
            ST_ADDR:  nib_out = req.addr[{acnt, 2'b00} +: 4];
            ST_CHAN:  nib_out = {req.tc, req.chan};
            ST_SIZE:  nib_out = {2'b00, req.size};
            ST_HDATA: nib_out = req.wdata[{bcnt, ncnt, 2'b00} +: 4];
            ST_HTAR1: nib_out = NIB_IDLE;
            ST_ABORT: frame_out = 1'b1;
            default:  nib_oe = 1'b0;
        endcase
    end

    assign req_ready  = (state == ST_IDLE);
    assign done_valid = (state == ST_DONE);
    assign done_err   = err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req   <= '0;
            acnt  <= '0;
            bcnt  <= '0;
            ncnt  <= 1'b0;
            err   <= 1'b0;
            abcnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    req.kind  <= xfer_kind_e'(req_kind);
                    req.write <= req_write;
                    req.addr  <= req_addr;
                    req.chan  <= req_chan;
                    req.tc    <= req_tc;
                    req.size  <= req_size;
                    req.wdata <= req_wdata;
                    acnt      <= (req_kind == K_MEM) ? 3'd7 : 3'd3;
                    bcnt      <= '0;
                    ncnt      <= 1'b0;
                    err       <= !new_ok;
                    state     <= new_ok ? ST_START : ST_DONE;
                end
                ST_START: state <= ST_CTYPE;
                ST_CTYPE: state <= (req.kind == K_DMA) ? ST_CHAN : ST_ADDR;
                ST_ADDR: begin
                    acnt <= acnt - 3'd1;
                    if (acnt == 3'd0)
                        state <= req.write ? ST_HDATA : ST_HTAR1;
                end
                ST_CHAN: state <= ST_SIZE;
                ST_SIZE: state <= req.write ? ST_HDATA : ST_HTAR1;
                ST_HDATA: begin
                    ncnt <= ~ncnt;
                    if (ncnt) state <= ST_HTAR1;
                end
                ST_HTAR1: state <= ST_HTAR2;
                ST_HTAR2: state <= ST_SYNC;
                ST_SYNC: begin
                    if (nib_in == SYNC_READY) begin
                        state <= req.write ? ST_PTAR1 : ST_PDATA;
                    end else if (nib_in == SYNC_ERR || tmo_expired) begin
                        err   <= 1'b1;
                        abcnt <= '0;
                        state <= ST_ABORT;
                    end
                end
                ST_PDATA: begin
                    ncnt <= ~ncnt;
                    if (ncnt) begin
                        if (bcnt != last_byte_idx(req)) begin
                            bcnt  <= bcnt + 2'd1;
                            state <= ST_SYNC;
                        end else begin
                            state <= ST_PTAR1;
                        end
                    end
                end
                ST_PTAR1: state <= ST_PTAR2;
                ST_PTAR2: begin
                    if (req.write && bcnt != last_byte_idx(req)) begin
                        bcnt  <= bcnt + 2'd1;
                        state <= ST_HDATA;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_ABORT: begin
                    abcnt <= abcnt + 1'b1;
                    if (abcnt == AB_LAST) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    start_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && new_ok) |=> (frame_out && nib_oe && nib_out == NIB_START));

    // R2
    frame_driven_chk: assert property (@(posedge clk) disable iff (rst)
        frame_out |-> nib_oe);

    // R11
    err_code_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYNC && nib_in == SYNC_ERR) |=> (frame_out && nib_out == NIB_IDLE));

    // R12
    timeout_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_expired && nib_in != SYNC_READY) |=> (state == ST_ABORT));

    // R13
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && !new_ok) |=> (done_valid && done_err && !frame_out));

    // R14
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (req_ready && !done_valid));

endmodule

// File: tb/lpc_host_seq_test.sv
module lpc_host_seq_test;
    localparam int TMO_W = 4;
    localparam int ABORT = 4;
    localparam logic [TMO_W-1:0] LIMIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_chan = '0;
    logic        req_tc = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  nib_in = 4'hF;
    logic        req_ready, done_valid, done_err, frame_out, nib_oe;
    logic [31:0] rd_data;
    logic [3:0]  nib_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lpc_host_seq #(.TMO_W(TMO_W), .ABORT_CLKS(ABORT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_chan(req_chan),
        .req_tc(req_tc), .req_size(req_size), .req_wdata(req_wdata),
        .tmo_limit(LIMIT), .req_ready(req_ready), .done_valid(done_valid),
        .done_err(done_err), .rd_data(rd_data), .frame_out(frame_out),
        .nib_out(nib_out), .nib_oe(nib_oe), .nib_in(nib_in)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // check one bus clock, then present drv on the input for the next edge
    task automatic cyc(input bit e_oe, input logic [3:0] e_nib, input bit e_fr,
                       input string rq, input logic [3:0] drv);
        chk(nib_oe === e_oe, {rq, " oe"}, 32'(nib_oe), 32'(e_oe));
        chk(frame_out === e_fr, {rq, " frame"}, 32'(frame_out), 32'(e_fr));
        if (e_oe) chk(nib_out === e_nib, {rq, " nibble"}, 32'(nib_out), 32'(e_nib));
        nib_in = drv;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [1:0] kind, input bit wr, input logic [31:0] addr,
                        input logic [2:0] chan, input bit tc, input logic [1:0] size,
                        input logic [31:0] wdata, input logic [31:0] rmodel,
                        input int waits, input logic [3:0] endcode);
        int  nb;
        bit  dma, aborted;
        logic [31:0] mask;
        dma = (kind == 2'd2);
        nb  = !dma ? 1 : (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : (size == 2'd3) ? 4 : 0;
        req_kind = kind; req_write = wr; req_addr = addr; req_chan = chan;
        req_tc = tc; req_size = size; req_wdata = wdata; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (nb == 0) begin
            // R13 rejected size code, no bus activity
            chk(done_valid && done_err && !frame_out && !nib_oe, "R13", 32'({done_valid, done_err, frame_out, nib_oe}), 32'b1100);
            @(posedge clk);
            @(negedge clk);
            chk(req_ready && !done_valid, "R14", 32'({req_ready, done_valid}), 32'b10);
            return;
        end
        cyc(1, 4'h0, 1, "R2", 4'hF);
        cyc(1, {dma, kind == 2'd1, dma ? ~wr : wr, 1'b0}, 0, "R3", 4'hF);
        if (dma) begin
            cyc(1, {tc, chan}, 0, "R5", 4'hF);
            cyc(1, {2'b00, size}, 0, "R5", 4'hF);
        end else begin
            for (int i = (kind == 2'd1) ? 7 : 3; i >= 0; i--)
                cyc(1, addr[4*i +: 4], 0, "R4", 4'hF);
        end
        aborted = 0;
        for (int b = 0; b < nb; b++) begin
            logic [3:0] code;
            code = (b == nb - 1) ? endcode : 4'h0;
            if (wr) begin
                cyc(1, wdata[8*b +: 4], 0, "R6", 4'hF);
                cyc(1, wdata[8*b+4 +: 4], 0, "R6", 4'hF);
            end
            if (wr || b == 0) begin
                cyc(1, 4'hF, 0, "R7", 4'hF);
                cyc(0, 4'hF, 0, "R7", 4'hF);
            end
            for (int w = 0; w < waits && w < int'(LIMIT); w++)
                cyc(0, 4'hF, 0, "R8", (w % 2) ? 4'h6 : 4'h5);
            if (waits >= int'(LIMIT)) begin aborted = 1; break; end  // R12
            cyc(0, 4'hF, 0, "R10", code);
            if (code == 4'hA) begin aborted = 1; break; end          // R11
            if (!wr) begin
                cyc(0, 4'hF, 0, "R9", rmodel[8*b +: 4]);
                cyc(0, 4'hF, 0, "R9", rmodel[8*b+4 +: 4]);
            end
            if (wr || b == nb - 1) begin
                cyc(0, 4'hF, 0, "R7", 4'hF);
                cyc(0, 4'hF, 0, "R7", 4'hF);
            end
        end
        if (aborted)
            for (int a = 0; a < ABORT; a++)
                cyc(1, 4'hF, 1, (waits >= int'(LIMIT)) ? "R12" : "R11", 4'hF);
        chk(done_valid === 1'b1, "R14", 32'(done_valid), 32'd1);
        chk(done_err === aborted, aborted ? "R11/R12 err" : "R8 err", 32'(done_err), 32'(aborted));
        if (!wr && !aborted) begin
            mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
            chk(rd_data === (rmodel & mask), "R9", rd_data, rmodel & mask);
        end
        @(posedge clk);
        @(negedge clk);
        chk(req_ready && !done_valid, "R14", 32'({req_ready, done_valid}), 32'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic [1:0] sizes[3];
        sizes[0] = 2'd0; sizes[1] = 2'd1; sizes[2] = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        chk(req_ready && !frame_out && !nib_oe && !done_valid, "R1",
            32'({req_ready, frame_out, nib_oe, done_valid}), 32'b1000);
        n = 0;
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < ((k == 2) ? 3 : 1); s++)
                    for (int wt = 0; wt < 3; wt++) begin
                        logic [31:0] a, d, r;
                        n++;
                        a = 32'h1357_9BDF ^ (32'(n) * 32'h9E37_79B9);
                        d = 32'hA5C3_0F96 + (32'(n) * 32'h0101_0103);
                        r = ~d ^ 32'h5A5A_1234;
                        xfer(2'(k), w[0], a, 3'(n), n[0], sizes[s], d, r, wt, 4'h0);
                    end
        // R11 error code on the last byte of a two-byte DMA write, and on an I/O read
        xfer(2'd2, 1'b1, 32'h0, 3'd5, 1'b1, 2'd1, 32'h0000_BEEF, 32'h0, 1, 4'hA);
        xfer(2'd0, 1'b0, 32'h0000_03F8, 3'd0, 1'b0, 2'd0, 32'h0, 32'h77, 0, 4'hA);
        // R12 timeout on memory write and on a four-byte DMA read
        xfer(2'd1, 1'b1, 32'hFEDC_BA98, 3'd0, 1'b0, 2'd0, 32'h42, 32'h0, 5, 4'h0);
        xfer(2'd2, 1'b0, 32'h0, 3'd7, 1'b0, 2'd3, 32'h0, 32'h1234_5678, 3, 4'h0);
        // R13 invalid DMA size
        xfer(2'd2, 1'b0, 32'h0, 3'd1, 1'b0, 2'd2, 32'h0, 32'h0, 0, 4'h0);
        xfer(2'd2, 1'b1, 32'h0, 3'd2, 1'b1, 2'd2, 32'h0, 32'h0, 0, 4'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule